// File: doc/BRIEF.md
# Hardwired Accumulator Control Sequencer

This block is the hardwired control unit of a small accumulator machine whose registers and main memory share one internal bus. A tick counter produces one timing line per clock cycle. Each timing line is ANDed with the decoded opcode of the instruction register to drive that cycle's micro-operations. The micro-operations are a 3-bit code naming the unit that drives the bus, a 3-bit code naming the unit that captures it, a capture enable, memory read and write strobes, a program counter increment, an ALU function and an accumulator write enable.

Every instruction begins with a three-cycle fetch. Execution follows, and the tick counter then returns to zero so that the next fetch begins. The instructions supported are direct load, direct add, indirect load, indirect store and accumulator clear. Any other opcode does nothing and returns at once to fetch. Indirect instructions read the operand address from memory: the memory buffer value is copied back into the memory address register, and a second memory access follows. The datapath registers and the memory are outside the block. The datapath supplies only the opcode field, which is bits 15..12 of a 16-bit instruction whose bits 11..0 hold an address.

Top module: `hw_ctl_seq`

## Requirements
- R1: Bus unit codes are MEM=0, MAR=1, PC=2, MBR=3, AC=4 and IR=5, where IR drives only its 12-bit address field. `bus_rd_sel` names the unit that drives the bus. `bus_wr_sel` names the unit that captures it, and the capture takes place only while `bus_wr_en`=1. In a cycle with no transfer, both codes are 0 and `bus_wr_en`=0.
- R2: Fetch takes ticks 0..2 for every opcode. Tick 0 moves PC to MAR. Tick 1 moves MEM to MBR with `mem_rd`=1. Tick 2 moves MBR to IR with `pc_inc`=1.
- R3: ADD (opcode 0011). Tick 3 moves IR to MAR. Tick 4 moves MEM to MBR with `mem_rd`. Tick 5 drives MBR on the bus with `alu_fn`=ADD and `ac_we`=1. Tick 0 follows.
- R4: LOAD (opcode 0001) follows the same steps as ADD, except that tick 5 uses `alu_fn`=PASS.
- R5: Indirect LOAD (opcode 1101). Tick 3 moves IR to MAR. Tick 4 moves MEM to MBR. Tick 5 moves MBR to MAR. Tick 6 moves MEM to MBR. Tick 7 drives MBR with `alu_fn`=PASS and `ac_we`. Tick 0 follows.
- R6: Indirect STORE (opcode 1110). Ticks 3..5 match R5. Tick 6 moves AC to MBR. Tick 7 moves MBR to MEM with `mem_wr`=1. Tick 0 follows.
- R7: CLEAR (opcode 1010) spends only tick 3, with `alu_fn`=ZERO, `ac_we`=1 and no bus transfer. Tick 0 follows.
- R8: Any other opcode spends only tick 3 with every control inactive (all outputs 0). Tick 0 follows.
- R9: Reset is synchronous and active low. It returns the sequencer to tick 0, and the first cycle after reset presents the fetch tick 0 controls.
- R10: `mem_rd` appears only with MEM driving and MBR capturing. `mem_wr` appears only with MBR driving and MEM capturing. The two strobes are never high together.
- R11: The `alu_fn` codes are NONE=0, PASS=1, ADD=2 and ZERO=3. `ac_we` is 1 exactly when `alu_fn` is not NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_opcode | input | 4 | Opcode field of the instruction register |
| bus_rd_sel | output | 3 | Code of the unit driving the bus |
| bus_wr_sel | output | 3 | Code of the unit capturing the bus |
| bus_wr_en | output | 1 | Capture enable for the unit in `bus_wr_sel` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_inc | output | 1 | Program counter increment |
| alu_fn | output | 2 | ALU function feeding the accumulator |
| ac_we | output | 1 | Accumulator write enable |

## Verification
The outputs are decoded from the tick counter in the same cycle, so a wrong tick count or a wrong restart shows as a wrong control word in the very cycle it occurs. The bench compares every cycle's control word with a behavioural model that queues the expected steps for each instruction. A decode fault, such as a misread opcode or a missing indirect hop, may leave the control words looking plausible while corrupting data. The bench therefore also runs a datapath and memory model from the outputs, and checks accumulator and memory contents a few cycles after the faulty instruction.

// File: rtl/seq_pkg.sv
// Package: shared encodings for the hardwired control sequencer.
// Assumes a 4-bit opcode and at most eight bus units.
package seq_pkg;
    localparam int OPC_W     = 4;
    localparam int UNIT_W    = 3;
    localparam int SEQ_TICKS = 8;

    typedef enum logic [UNIT_W-1:0] {
        UNIT_MEM = 3'd0,
        UNIT_MAR = 3'd1,
        UNIT_PC  = 3'd2,
        UNIT_MBR = 3'd3,
        UNIT_AC  = 3'd4,
        UNIT_IR  = 3'd5
    } unit_e;

    typedef enum logic [1:0] {
        ALU_NONE = 2'd0,
        ALU_PASS = 2'd1,
        ALU_ADD  = 2'd2,
        ALU_ZERO = 2'd3
    } alu_e;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 4'h1;
    localparam logic [OPC_W-1:0] OPC_ADD    = 4'h3;
    localparam logic [OPC_W-1:0] OPC_CLEAR  = 4'hA;
    localparam logic [OPC_W-1:0] OPC_LOADI  = 4'hD;
    localparam logic [OPC_W-1:0] OPC_STOREI = 4'hE;

    typedef struct packed {
        logic is_load;
        logic is_add;
        logic is_clear;
        logic is_loadi;
        logic is_storei;
        logic is_other;
    } dec_t;

    typedef struct packed {
        unit_e rd;
        unit_e wr;
        logic  wr_en;
        logic  mem_rd;
        logic  mem_wr;
        logic  pc_inc;
        alu_e  alu;
        logic  ac_we;
    } uop_t;

    localparam uop_t UOP_IDLE = '{rd: UNIT_MEM, wr: UNIT_MEM, wr_en: 1'b0,
                                  mem_rd: 1'b0, mem_wr: 1'b0, pc_inc: 1'b0,
                                  alu: ALU_NONE, ac_we: 1'b0};

    // Build a plain register-to-register bus transfer.
    function automatic uop_t mk_xfer(unit_e src, unit_e dst);
        uop_t u;
        u       = UOP_IDLE;
        u.rd    = src;
        u.wr    = dst;
        u.wr_en = 1'b1;
        return u;
    endfunction

    // Build a memory read into the buffer register.
    function automatic uop_t mk_mem_read();
        uop_t u;
        u        = mk_xfer(UNIT_MEM, UNIT_MBR);
        u.mem_rd = 1'b1;
        return u;
    endfunction

    // Build a memory write from the buffer register.
    function automatic uop_t mk_mem_write();
        uop_t u;
        u        = mk_xfer(UNIT_MBR, UNIT_MEM);
        u.mem_wr = 1'b1;
        return u;
    endfunction

    // Build an accumulator update with the buffer register as operand.
    function automatic uop_t mk_acc(alu_e fn, unit_e src);
        uop_t u;
        u       = UOP_IDLE;
        u.rd    = src;
        u.alu   = fn;
        u.ac_we = 1'b1;
        return u;
    endfunction
endpackage

// File: rtl/seq_tick_gen.sv
// Module: tick generator. Counts clock ticks within one instruction and
// presents them as one-hot timing lines. Assumes restart is asserted no
// later than the last tick; the count holds at the last tick otherwise.
module seq_tick_gen #(
    parameter int NUM_TICKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    output logic [NUM_TICKS-1:0] tick_oh
);
    localparam int CNT_W = (NUM_TICKS > 1) ? $clog2(NUM_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance the tick count, or return to zero on restart or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (cnt_q != CNT_LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // Decode the count into one timing line per tick.
    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_tick
        assign tick_oh[g] = (cnt_q == CNT_W'(g));
    end

    assert_one_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tick_oh) == 1);
    assert_restart_to_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> tick_oh[0]);
    assert_tick_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick_oh[NUM_TICKS-1]) |=> tick_oh == ($past(tick_oh) << 1));
    assert_last_tick_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_oh[NUM_TICKS-1] |-> restart);
endmodule

// File: rtl/seq_op_decode.sv
// Module: opcode decoder. Turns the opcode field into one decoded line per
// supported instruction plus a catch-all line for unknown opcodes.
// Assumes the opcode is stable from the tick after fetch completes.
module seq_op_decode
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    // Compare the opcode against each supported encoding.
    always_comb begin
        dec           = '0;
        dec.is_load   = (opcode == OPC_LOAD);
        dec.is_add    = (opcode == OPC_ADD);
        dec.is_clear  = (opcode == OPC_CLEAR);
        dec.is_loadi  = (opcode == OPC_LOADI);
        dec.is_storei = (opcode == OPC_STOREI);
        dec.is_other  = !(dec.is_load || dec.is_add || dec.is_clear ||
                          dec.is_loadi || dec.is_storei);
    end

    assert_one_decode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dec) == 1);
endmodule

// File: rtl/seq_uop_matrix.sv
// Module: micro-operation matrix. ANDs each timing line with the decoded
// instruction lines to form that tick's control word, and flags the last
// tick of the instruction. Assumes exactly one timing line is active.
module seq_uop_matrix
    import seq_pkg::*;
#(
    parameter int NUM_TICKS = SEQ_TICKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TICKS-1:0] tick_oh,
    input  dec_t                 dec,
    output uop_t                 uop,
    output logic                 last
);
    logic mem_op;
    logic indirect;

    // Group the decoded lines that share execution steps.
    always_comb begin
        mem_op   = dec.is_load || dec.is_add || dec.is_loadi || dec.is_storei;
        indirect = dec.is_loadi || dec.is_storei;
    end

    // Select the control word for the active tick and decoded instruction.
    always_comb begin
        uop  = UOP_IDLE;
        last = 1'b0;
        if (tick_oh[0]) begin
            uop = mk_xfer(UNIT_PC, UNIT_MAR);
        end
        if (tick_oh[1]) begin
            uop = mk_mem_read();
        end
        if (tick_oh[2]) begin
            uop        = mk_xfer(UNIT_MBR, UNIT_IR);
            uop.pc_inc = 1'b1;
        end
        if (tick_oh[3]) begin
            if (mem_op) begin
                uop = mk_xfer(UNIT_IR, UNIT_MAR);
            end
            if (dec.is_clear) begin
                uop       = UOP_IDLE;
                uop.alu   = ALU_ZERO;
                uop.ac_we = 1'b1;
                last      = 1'b1;
            end
            if (dec.is_other) begin
                last = 1'b1;
            end
        end
        if (tick_oh[4] && mem_op) begin
            uop = mk_mem_read();
        end
        if (tick_oh[5]) begin
            if (dec.is_load) begin
                uop  = mk_acc(ALU_PASS, UNIT_MBR);
                last = 1'b1;
            end
            if (dec.is_add) begin
                uop  = mk_acc(ALU_ADD, UNIT_MBR);
                last = 1'b1;
            end
            if (indirect) begin
                uop = mk_xfer(UNIT_MBR, UNIT_MAR);
            end
        end
        if (tick_oh[6]) begin
            if (dec.is_loadi) begin
                uop = mk_mem_read();
            end
            if (dec.is_storei) begin
                uop = mk_xfer(UNIT_AC, UNIT_MBR);
            end
        end
        if (tick_oh[7]) begin
            if (dec.is_loadi) begin
                uop = mk_acc(ALU_PASS, UNIT_MBR);
            end
            if (dec.is_storei) begin
                uop = mk_mem_write();
            end
            last = 1'b1;
        end
    end

    assert_rd_strobe_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uop.mem_rd |-> (uop.rd == UNIT_MEM && uop.wr == UNIT_MBR && uop.wr_en));
    assert_wr_strobe_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uop.mem_wr |-> (uop.rd == UNIT_MBR && uop.wr == UNIT_MEM && uop.wr_en));
    assert_no_rdwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(uop.mem_rd && uop.mem_wr));
    assert_acc_we_alu_R11: assert property (@(posedge clk) disable iff (!rst_n)
        uop.ac_we == (uop.alu != ALU_NONE));
    assert_indirect_hop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_oh[5] && indirect) |=> uop.mem_rd || (uop.rd == UNIT_AC && uop.wr == UNIT_MBR));
endmodule

// File: rtl/hw_ctl_seq.sv
// Module: top of the hardwired control sequencer. Connects the tick
// generator, opcode decoder and micro-operation matrix, and breaks the
// control word out onto plain ports. Assumes the datapath loads the
// instruction register from the bus at fetch tick 2.
module hw_ctl_seq
    import seq_pkg::*;
#(
    parameter int NUM_TICKS = SEQ_TICKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  ir_opcode,
    output logic [UNIT_W-1:0] bus_rd_sel,
    output logic [UNIT_W-1:0] bus_wr_sel,
    output logic              bus_wr_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              pc_inc,
    output logic [1:0]        alu_fn,
    output logic              ac_we
);
    logic [NUM_TICKS-1:0] tick_oh;
    dec_t                 dec;
    uop_t                 uop;
    logic                 last;

    seq_tick_gen #(.NUM_TICKS(NUM_TICKS)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (last),
        .tick_oh (tick_oh)
    );

    seq_op_decode dec_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_opcode),
        .dec    (dec)
    );

    seq_uop_matrix #(.NUM_TICKS(NUM_TICKS)) mtx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_oh (tick_oh),
        .dec     (dec),
        .uop     (uop),
        .last    (last)
    );

    // Break the control word out onto the port list.
    always_comb begin
        bus_rd_sel = uop.rd;
        bus_wr_sel = uop.wr;
        bus_wr_en  = uop.wr_en;
        mem_rd     = uop.mem_rd;
        mem_wr     = uop.mem_wr;
        pc_inc     = uop.pc_inc;
        alu_fn     = uop.alu;
        ac_we      = uop.ac_we;
    end

    assert_clear_one_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fn == 2'd3) |=> (bus_rd_sel == 3'd2 && bus_wr_sel == 3'd1 && bus_wr_en));
    assert_fetch_then_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> !pc_inc && !mem_rd && !mem_wr);
    assert_store_then_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (bus_rd_sel == 3'd2 && bus_wr_sel == 3'd1));
    assert_idle_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |-> (bus_wr_sel == 3'd0 && !mem_rd && !mem_wr));
endmodule

// File: tb/hw_ctl_seq_tb.sv
// Bench: behavioural reference of the expected control word per cycle,
// plus a datapath and memory model driven by the design's outputs.
module hw_ctl_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 100;
    localparam int RESET_AT   = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ir_opcode;
    logic [2:0] bus_rd_sel, bus_wr_sel;
    logic       bus_wr_en, mem_rd, mem_wr, pc_inc, ac_we;
    logic [1:0] alu_fn;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_ctl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode),
        .bus_rd_sel(bus_rd_sel), .bus_wr_sel(bus_wr_sel), .bus_wr_en(bus_wr_en),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_inc(pc_inc),
        .alu_fn(alu_fn), .ac_we(ac_we)
    );

    // Datapath model
    logic [15:0] mem [4096];
    logic [11:0] pc, mar;
    logic [15:0] mbr, ac, ir;
    assign ir_opcode = ir[15:12];

    // Expected control words: {rd, wr, wr_en, mem_rd, mem_wr, pc_inc, alu, ac_we}
    logic [12:0] exp_q [$];
    string       tag_q [$];
    bit          need_exec;

    function automatic logic [12:0] cw(int rd, int wr, bit we, bit mr, bit mw,
                                       bit pi, int alu, bit acw);
        return {3'(rd), 3'(wr), we, mr, mw, pi, 2'(alu), acw};
    endfunction

    task automatic push(logic [12:0] w, string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    task automatic push_fetch(string t0);
        push(cw(2, 1, 1, 0, 0, 0, 0, 0), t0);
        push(cw(0, 3, 1, 1, 0, 0, 0, 0), "R2");
        push(cw(3, 5, 1, 0, 0, 1, 0, 0), "R2");
    endtask

    task automatic push_exec(logic [3:0] op);
        case (op)
            4'h1, 4'h3: begin
                string t = (op == 4'h1) ? "R4" : "R3";
                push(cw(5, 1, 1, 0, 0, 0, 0, 0), t);
                push(cw(0, 3, 1, 1, 0, 0, 0, 0), t);
                push(cw(3, 0, 0, 0, 0, 0, (op == 4'h1) ? 1 : 2, 1), t);
            end
            4'hD, 4'hE: begin
                string t = (op == 4'hD) ? "R5" : "R6";
                push(cw(5, 1, 1, 0, 0, 0, 0, 0), t);
                push(cw(0, 3, 1, 1, 0, 0, 0, 0), t);
                push(cw(3, 1, 1, 0, 0, 0, 0, 0), t);
                if (op == 4'hD) begin
                    push(cw(0, 3, 1, 1, 0, 0, 0, 0), t);
                    push(cw(3, 0, 0, 0, 0, 0, 1, 1), t);
                end else begin
                    push(cw(4, 3, 1, 0, 0, 0, 0, 0), t);
                    push(cw(3, 0, 1, 0, 1, 0, 0, 0), t);
                end
            end
            4'hA:    push(cw(0, 0, 0, 0, 0, 0, 3, 1), "R7");
            default: push(cw(0, 0, 0, 0, 0, 0, 0, 0), "R8");
        endcase
    endtask

    task automatic check16(string t, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // Apply one cycle's controls to the datapath model.
    task automatic apply_controls();
        logic [15:0] bus;
        case (bus_rd_sel)
            3'd0: bus = mem[mar];
            3'd1: bus = {4'h0, mar};
            3'd2: bus = {4'h0, pc};
            3'd3: bus = mbr;
            3'd4: bus = ac;
            3'd5: bus = {4'h0, ir[11:0]};
            default: bus = 16'h0;
        endcase
        if (bus_wr_en) begin
            case (bus_wr_sel)
                3'd0: if (mem_wr) mem[mar] = bus;
                3'd1: mar = bus[11:0];
                3'd2: pc  = bus[11:0];
                3'd3: mbr = bus;
                3'd4: ac  = bus;
                3'd5: ir  = bus;
                default: ;
            endcase
        end
        if (pc_inc) pc = pc + 12'd1;
        if (ac_we) begin
            case (alu_fn)
                2'd1: ac = bus;
                2'd2: ac = ac + bus;
                2'd3: ac = 16'h0;
                default: ;
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
        mem[0]  = 16'h1100;   // LOAD 100        -> AC=5
        mem[1]  = 16'h3101;   // ADD 101         -> AC=12
        mem[2]  = 16'hE102;   // STOREI 102      -> mem[200]=12
        mem[3]  = 16'hA000;   // CLEAR           -> AC=0
        mem[4]  = 16'h3100;   // ADD 100         -> AC=5
        mem[5]  = 16'hE105;   // STOREI 105      -> mem[301]=5
        mem[6]  = 16'h7000;   // unknown opcode
        mem[7]  = 16'hD103;   // LOADI 103       -> AC=12
        mem[8]  = 16'h3100;   // ADD 100         -> AC=17
        mem[9]  = 16'hE104;   // STOREI 104      -> mem[300]=17
        mem[12'h100] = 16'd5;
        mem[12'h101] = 16'd7;
        mem[12'h102] = 16'h0200;
        mem[12'h103] = 16'h0200;
        mem[12'h104] = 16'h0300;
        mem[12'h105] = 16'h0301;
        pc = '0; mar = '0; mbr = '0; ac = '0; ir = '0;
        need_exec = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            logic [12:0] act, exp;
            string       t;
            @(negedge clk);
            if (!rst_n) begin
                exp_q.delete();
                tag_q.delete();
                need_exec = 1'b0;
                rst_n = 1'b1;
                push_fetch("R9");
                need_exec = 1'b1;
            end
            if (exp_q.size() == 0) begin
                if (need_exec) push_exec(ir[15:12]);
                else           push_fetch("R2");
                need_exec = !need_exec;
            end
            exp = exp_q.pop_front();
            t   = tag_q.pop_front();
            act = {bus_rd_sel, bus_wr_sel, bus_wr_en, mem_rd, mem_wr, pc_inc, alu_fn, ac_we};
            n_checks++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s R1 R10 R11 cycle %0d: actual %b expected %b", t, cyc, act, exp);
            end
            apply_controls();
            if (cyc == RESET_AT) rst_n = 1'b0;
        end
        check16("R3 final accumulator", ac, 16'd17);
        check16("R6 indirect store before clear", mem[12'h200], 16'd12);
        check16("R7 store after clear and add", mem[12'h301], 16'd5);
        check16("R5 indirect load then add stored", mem[12'h300], 16'd17);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule